// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

This block carries out the shift and rotate family of an integer datapath on a byte or a word operand. One operation is accepted per cycle; a cycle later it delivers the shifted or rotated value together with new values for the carry, overflow, parity, sign and zero flags. A five-bit write mask tells the flag register which of those values it should take. The step count comes either from an immediate field or from the count register, as picked by a select input. Only the low five bits of the chosen count are used.

Every operation is built as a chain of identical one-position stages. Stage k is active when the count is greater than k. Because of this, counts above the operand width behave exactly as that many single-bit steps would: shifts drain to zero or to sign fill, and rotates wrap around. In byte mode the upper byte of the operand goes through unchanged, and all flags are taken from the low byte.

Top module: `shrot_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge appears on `result`, the flag outputs and `flag_wr` after that edge, with `out_valid` high for exactly that one cycle. `out_valid` is low in every cycle that follows an edge at which `in_valid` was low.
- R2: The count is `cl_cnt` when `cnt_sel` is 1 and `imm_cnt` when it is 0. Only its low five bits are used, so 33 acts as 1 and 32 acts as 0.
- R3: An effective count of zero returns the operand unchanged with `flag_wr` = 0.
- R4: Opcode 0 is a logical left shift: each step moves the MSB into CF and puts 0 into the LSB. Opcode 1 is a logical right shift: each step moves the LSB into CF and puts 0 into the MSB.
- R5: Opcode 2 is an arithmetic right shift: each step moves the LSB into CF and leaves the MSB as it was.
- R6: Opcode 3 rotates left, copying the MSB into both CF and the LSB. Opcode 4 rotates right, copying the LSB into both CF and the MSB.
- R7: Opcode 5 rotates left through carry (MSB to CF, old CF to LSB). Opcode 6 rotates right through carry (LSB to CF, old CF to MSB).
- R8: The bits of `flag_wr` are 0 = CF, 1 = OF, 2 = PF, 3 = SF, 4 = ZF. With a nonzero count, plain rotates write 5'b00011, the arithmetic right shift writes 5'b11101, and the other shifts and the carry rotates write 5'b11111.
- R9: PF is 1 when the low result byte has an even number of ones. SF is the result MSB. ZF is 1 when the result (at the selected width) is zero.
- R10: For left operations OF is the result MSB xor the new CF. For right operations it is the xor of the two top result bits. The same rule is applied for every nonzero count.
- R11: With `wide` = 0 the operation acts on bits 7:0, bit 7 is the MSB, and `result[15:8]` equals `operand[15:8]`.
- R12: Opcode 7 is a no-op: the result equals the operand and `flag_wr` = 0.
- R13: After reset `out_valid`, `result` and `flag_wr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 16 | Value to shift or rotate |
| wide | input | 1 | 1 = word, 0 = byte |
| op | input | 3 | Operation code (R4 to R7, R12) |
| cnt_sel | input | 1 | 1 = count register, 0 = immediate |
| imm_cnt | input | 8 | Immediate count |
| cl_cnt | input | 8 | Count register value |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Shifted or rotated value |
| cf | output | 1 | New carry flag |
| of | output | 1 | New overflow flag |
| pf | output | 1 | New parity flag |
| sf | output | 1 | New sign flag |
| zf | output | 1 | New zero flag |
| flag_wr | output | 5 | Per-flag write mask |

## Verification
The bench builds the unit with its default parameters: a 16-bit datapath, an 8-bit narrow mode and a five-bit count. With these values, counts up to 31 can exceed both operand widths. This covers shifts that drain to zero or to sign fill, plain rotates that wrap several times, and carry rotates whose count is an exact multiple of the 9-bit or 17-bit ring. The reference model works on whole words with wide shifts and modulo ring rotation rather than single steps. Byte mode, immediate versus register count, counts masked to zero, and long back-to-back bursts are all compared through a queue.

// File: rtl/shrot_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes: opcode values are fixed by the decoder that feeds the unit.
package shrot_pkg;
    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shrot_op_e;

    localparam int FLAG_N = 5;
    localparam int FB_CF  = 0;
    localparam int FB_OF  = 1;
    localparam int FB_PF  = 2;
    localparam int FB_SF  = 3;
    localparam int FB_ZF  = 4;
endpackage

// File: rtl/shrot_count_sel.sv
// Picks the count source and keeps only the low COUNT_W bits (R2).
// Assumes: both count inputs have the same width.
module shrot_count_sel #(
    parameter int CNT_IN_W = 8,
    parameter int COUNT_W  = 5
) (
    input  logic                cnt_sel,
    input  logic [CNT_IN_W-1:0] imm_cnt,
    input  logic [CNT_IN_W-1:0] cl_cnt,
    output logic [COUNT_W-1:0]  cnt_eff,
    output logic                cnt_zero
);
    logic [CNT_IN_W-1:0] picked;
    logic                unused_hi;

    // select the count source and truncate it
    always_comb begin
        picked    = cnt_sel ? cl_cnt : imm_cnt;
        cnt_eff   = picked[COUNT_W-1:0];
        cnt_zero  = (cnt_eff == '0);
        unused_hi = ^picked[CNT_IN_W-1:COUNT_W];
    end
endmodule

// File: rtl/shrot_core.sv
// Chain of 2**COUNT_W-1 one-position stages. Stage k acts when count > k.
// Assumes: in narrow mode only the low NARROW_W bits matter; upper bits of
// res are zero and the caller merges the upper operand bits back in.
module shrot_core
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int COUNT_W  = 5
) (
    input  logic [DATA_W-1:0]  operand,
    input  logic               wide,
    input  shrot_op_e          op,
    input  logic [COUNT_W-1:0] cnt,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  res,
    output logic               cf_out
);
    localparam int STAGES = (1 << COUNT_W) - 1;
    localparam int IDX_W  = $clog2(DATA_W);

    logic [DATA_W-1:0] wmask;
    logic [IDX_W-1:0]  msb_idx;
    logic [DATA_W-1:0] val [STAGES+1];
    logic              car [STAGES+1];

    // width mask and MSB position for the chosen operand size
    always_comb begin
        wmask   = wide ? {DATA_W{1'b1}} : DATA_W'({NARROW_W{1'b1}});
        msb_idx = wide ? IDX_W'(DATA_W - 1) : IDX_W'(NARROW_W - 1);
    end

    assign val[0] = operand & wmask;
    assign car[0] = carry_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [DATA_W-1:0] lft, rgt, nv;
        logic              top, bot, nc;

        // one position of the selected operation, gated by the count
        always_comb begin
            top = val[k][msb_idx];
            bot = val[k][0];
            lft = (val[k] << 1) & wmask;
            rgt = val[k] >> 1;
            nv  = val[k];
            nc  = car[k];
            unique case (op)
                OP_SHL: begin nv = lft; nc = top; end
                OP_SHR: begin nv = rgt; nc = bot; end
                OP_SAR: begin nv = rgt; nv[msb_idx] = top; nc = bot; end
                OP_ROL: begin nv = lft; nv[0] = top; nc = top; end
                OP_ROR: begin nv = rgt; nv[msb_idx] = bot; nc = bot; end
                OP_RCL: begin nv = lft; nv[0] = car[k]; nc = top; end
                OP_RCR: begin nv = rgt; nv[msb_idx] = car[k]; nc = bot; end
                default: begin nv = val[k]; nc = car[k]; end
            endcase
            if (!(cnt > COUNT_W'(k))) begin
                nv = val[k];
                nc = car[k];
            end
        end

        assign val[k+1] = nv;
        assign car[k+1] = nc;
    end

    assign res    = val[STAGES];
    assign cf_out = car[STAGES];
endmodule

// File: rtl/shrot_flags.sv
// Derives flag values and the per-flag write mask from the shifted value.
// Assumes: res is already masked to the selected width.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    input  shrot_op_e         op,
    input  logic              cnt_zero,
    input  logic              cf_new,
    output logic [FLAG_N-1:0] flag_val,
    output logic [FLAG_N-1:0] flag_wr
);
    logic r_msb, r_sub;

    // flag values: parity on low byte, sign, zero, overflow rule
    always_comb begin
        r_msb = wide ? res[DATA_W-1] : res[NARROW_W-1];
        r_sub = wide ? res[DATA_W-2] : res[NARROW_W-2];
        flag_val         = '0;
        flag_val[FB_CF]  = cf_new;
        flag_val[FB_PF]  = ~^res[7:0];
        flag_val[FB_SF]  = r_msb;
        flag_val[FB_ZF]  = (res == '0);
        if (op == OP_SHL || op == OP_ROL || op == OP_RCL)
            flag_val[FB_OF] = r_msb ^ cf_new;
        else
            flag_val[FB_OF] = r_msb ^ r_sub;
    end

    // write mask per operation class
    always_comb begin
        if (cnt_zero || op == OP_NOP)
            flag_wr = '0;
        else if (op == OP_ROL || op == OP_ROR)
            flag_wr = FLAG_N'(5'b00011);
        else if (op == OP_SAR)
            flag_wr = FLAG_N'(5'b11101);
        else
            flag_wr = '1;
    end
endmodule

// File: rtl/shrot_unit.sv
// Top of the shift/rotate unit: count selection, stage chain, flag
// generation and one output register stage.
// Assumes: one operation per cycle, no back-pressure from the consumer.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int COUNT_W  = 5,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   operand,
    input  logic                wide,
    input  logic [2:0]          op,
    input  logic                cnt_sel,
    input  logic [CNT_IN_W-1:0] imm_cnt,
    input  logic [CNT_IN_W-1:0] cl_cnt,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                cf,
    output logic                of,
    output logic                pf,
    output logic                sf,
    output logic                zf,
    output logic [FLAG_N-1:0]   flag_wr
);
    shrot_op_e          op_e;
    logic [COUNT_W-1:0] cnt_eff;
    logic               cnt_zero;
    logic [DATA_W-1:0]  core_res, full_res, keep_mask;
    logic               core_cf;
    logic [FLAG_N-1:0]  fval, fwr, fval_q;

    assign op_e = shrot_op_e'(op);

    shrot_count_sel #(.CNT_IN_W(CNT_IN_W), .COUNT_W(COUNT_W)) u_cnt (
        .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .cl_cnt(cl_cnt),
        .cnt_eff(cnt_eff), .cnt_zero(cnt_zero)
    );

    shrot_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .COUNT_W(COUNT_W)) u_core (
        .operand(operand), .wide(wide), .op(op_e), .cnt(cnt_eff),
        .carry_in(carry_in), .res(core_res), .cf_out(core_cf)
    );

    shrot_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
        .res(core_res), .wide(wide), .op(op_e), .cnt_zero(cnt_zero),
        .cf_new(core_cf), .flag_val(fval), .flag_wr(fwr)
    );

    // merge untouched upper bits back in narrow mode
    always_comb begin
        keep_mask = wide ? '0 : ~DATA_W'({NARROW_W{1'b1}});
        full_res  = (operand & keep_mask) | core_res;
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            fval_q    <= '0;
            flag_wr   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= full_res;
                fval_q  <= fval;
                flag_wr <= fwr;
            end
        end
    end

    assign cf = fval_q[FB_CF];
    assign of = fval_q[FB_OF];
    assign pf = fval_q[FB_PF];
    assign sf = fval_q[FB_SF];
    assign zf = fval_q[FB_ZF];

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_zero_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_zero) |=> (result == $past(operand) && flag_wr == '0));
    p_rot_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_zero && (op_e == OP_ROL || op_e == OP_ROR))
        |=> (flag_wr == FLAG_N'(5'b00011)));
    p_narrow_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[DATA_W-1:NARROW_W] == $past(operand[DATA_W-1:NARROW_W])));
    p_sar_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && op_e == OP_SAR) |=> (result[DATA_W-1] == $past(operand[DATA_W-1])));
    p_nop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_NOP) |=> (flag_wr == '0 && result == $past(operand)));
endmodule

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] operand = '0;
    logic        wide = 1'b0;
    logic [2:0]  op = '0;
    logic        cnt_sel = 1'b0;
    logic [7:0]  imm_cnt = '0;
    logic [7:0]  cl_cnt = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic        cf, of, pf, sf, zf;
    logic [4:0]  flag_wr;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [15:0] res;
        logic [4:0]  fv;
        logic [4:0]  wr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .wide(wide), .op(op), .cnt_sel(cnt_sel), .imm_cnt(imm_cnt),
        .cl_cnt(cl_cnt), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .cf(cf), .of(of), .pf(pf), .sf(sf), .zf(zf),
        .flag_wr(flag_wr)
    );

    // Reference model built on whole-word shifts and modulo ring rotation.
    function automatic exp_t model(input logic [15:0] v_in, input logic w,
                                   input logic [2:0] o, input logic [7:0] raw,
                                   input logic cin, input string tag);
        exp_t        e;
        int          W = w ? 16 : 8;
        int          n = int'(raw[4:0]);
        int          k;
        logic [31:0] wm = w ? 32'hFFFF : 32'h00FF;
        logic [31:0] v  = {16'b0, v_in} & wm;
        logic [31:0] r, ring, rmask, rr;
        logic [63:0] t;
        logic signed [63:0] s;
        logic        c, msb, sub;
        e.tag = tag;
        r = v; c = cin;
        case (o)
            3'd0: begin t = {32'b0, v} << n; r = t[31:0] & wm; c = t[W]; end
            3'd1: begin t = {31'b0, v, 1'b0} >> n; r = t[32:1]; c = t[0]; end
            3'd2: begin
                s = w ? {{48{v[15]}}, v[15:0]} : {{56{v[7]}}, v[7:0]};
                s = (s <<< 1) >>> n;
                r = s[32:1] & wm; c = s[0];
            end
            3'd3: begin k = n % W; r = ((v << k) | (v >> (W - k))) & wm; c = r[0]; end
            3'd4: begin k = n % W; r = ((v >> k) | (v << (W - k))) & wm; c = r[W-1]; end
            3'd5: begin
                ring = v | (32'(cin) << W); rmask = (32'd1 << (W + 1)) - 1;
                k = n % (W + 1);
                rr = ((ring << k) | (ring >> (W + 1 - k))) & rmask;
                r = rr & wm; c = rr[W];
            end
            3'd6: begin
                ring = v | (32'(cin) << W); rmask = (32'd1 << (W + 1)) - 1;
                k = n % (W + 1);
                rr = ((ring >> k) | (ring << (W + 1 - k))) & rmask;
                r = rr & wm; c = rr[W];
            end
            default: begin r = v; c = cin; end
        endcase
        msb = r[W-1]; sub = r[W-2];
        e.fv[0] = c;
        e.fv[1] = (o == 3'd0 || o == 3'd3 || o == 3'd5) ? (msb ^ c) : (msb ^ sub);
        e.fv[2] = ~^r[7:0];
        e.fv[3] = msb;
        e.fv[4] = (r == 0);
        if (n == 0 || o == 3'd7) begin
            e.wr = 5'b00000; e.res = v_in;
        end else begin
            e.wr  = (o == 3'd3 || o == 3'd4) ? 5'b00011 : (o == 3'd2) ? 5'b11101 : 5'b11111;
            e.res = (v_in & ~wm[15:0]) | r[15:0];
        end
        return e;
    endfunction

    // Driver: present one operation for one cycle and queue the expectation.
    task automatic drive(input logic [15:0] v, input logic w, input logic [2:0] o,
                         input logic sel, input logic [7:0] imm, input logic [7:0] cl,
                         input logic cin, input string tag);
        @(negedge clk);
        operand = v; wide = w; op = o; cnt_sel = sel; imm_cnt = imm;
        cl_cnt = cl; carry_in = cin; in_valid = 1'b1;
        sb_q.push_back(model(v, w, o, sel ? cl : imm, cin, tag));
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare each produced result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            logic bad;
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected out_valid, result=%h expected no output", result);
            end else begin
                e = sb_q.pop_front();
                bad = (result !== e.res) || (flag_wr !== e.wr);
                for (int b = 0; b < 5; b++)
                    if (e.wr[b] && ({zf, sf, pf, of, cf}[b] !== e.fv[b])) bad = 1'b1;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: result=%h wr=%b flags(zspoc)=%b expected result=%h wr=%b flags=%b",
                             e.tag, result, flag_wr, {zf, sf, pf, of, cf}, e.res, e.wr, e.fv);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, queue=%0d expected 0", sb_q.size());
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        // R13: reset state
        n_tests++;
        if (out_valid !== 1'b0 || result !== 16'h0 || flag_wr !== 5'h0) begin
            n_fail++;
            $display("FAIL R13: valid=%b result=%h wr=%b expected 0 0000 00000",
                     out_valid, result, flag_wr);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(16'h8001, 1, 3'd0, 0, 8'd1, 8'd0, 0, "R4 shl word by 1");
        drive(16'hAB81, 0, 3'd1, 0, 8'd3, 8'd0, 1, "R4 R11 shr byte by 3");
        drive(16'h9234, 1, 3'd2, 0, 8'd3, 8'd0, 0, "R5 sar negative word");
        drive(16'h1283, 0, 3'd2, 0, 8'd12, 8'd0, 0, "R5 sar byte beyond width");
        drive(16'h1234, 1, 3'd3, 0, 8'd4, 8'd0, 1, "R6 rol word by 4");
        drive(16'h5501, 0, 3'd4, 0, 8'd9, 8'd0, 0, "R6 ror byte wrap 9");
        drive(16'h8000, 1, 3'd5, 0, 8'd1, 8'd0, 1, "R7 rcl word cin=1");
        drive(16'hC3A5, 1, 3'd6, 0, 8'd17, 8'd0, 1, "R7 rcr full ring");
        drive(16'h0081, 0, 3'd6, 0, 8'd2, 8'd0, 0, "R7 rcr byte by 2");
        drive(16'hFFFF, 1, 3'd0, 0, 8'd20, 8'd0, 0, "R9 shl drains to zero");
        drive(16'h0003, 1, 3'd0, 1, 8'd0, 8'd2, 0, "R2 count from register");
        drive(16'h0003, 1, 3'd1, 0, 8'd33, 8'd5, 0, "R2 immediate masked 33");
        drive(16'hBEEF, 1, 3'd0, 1, 8'd3, 8'd32, 1, "R3 masked count zero");
        drive(16'h4321, 0, 3'd5, 0, 8'd0, 8'd0, 1, "R3 zero immediate");
        drive(16'h7E5A, 1, 3'd7, 0, 8'd5, 8'd0, 1, "R12 reserved opcode");
        drive(16'hC000, 1, 3'd1, 0, 8'd1, 8'd0, 0, "R10 shr of by 1");
        drive(16'h4000, 1, 3'd0, 0, 8'd1, 8'd0, 0, "R10 shl of by 1");
        drive(16'h00C0, 0, 3'd3, 0, 8'd1, 8'd0, 0, "R8 R10 rol byte mask");
        drive(16'hA580, 0, 3'd2, 0, 8'd1, 8'd0, 0, "R8 R11 sar byte mask");
        idle(3);

        // R1: valid pulse tracking with gaps
        drive(16'h0F0F, 1, 3'd4, 0, 8'd8, 8'd0, 0, "R1 R6 ror after gap");
        idle(1);
        drive(16'h00FF, 0, 3'd0, 0, 8'd8, 8'd0, 0, "R1 R9 shl byte to zero");
        idle(2);

        // Mixed burst over all opcodes, widths and counts
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr[15:0], lfsr[16], lfsr[19:17], lfsr[20], {2'b0, lfsr[26:21]},
                  {3'b0, lfsr[31:27]}, lfsr[7], "R4 R5 R6 R7 R9 R10 R11 burst");
        end
        idle(4);

        n_tests++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: %0d results missing, expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule